// File: doc/BRIEF.md
# Calendar Timekeeper with Deferred Register Commit

This block keeps wall-clock time (seconds, minutes, hours) and a calendar date (day of month, month, year) and advances them by one second for every single-cycle pulse on the `tick` input. Seconds and minutes wrap at 60 and hours at 24. Days wrap at the length of the current month. After December the year steps forward, and a stored leap flag sets how long February is. The year is kept as an 8-bit offset from a base year of 1970, so it covers 1970 to 2225.

Software sees three 32-bit words on a simple register bus: a control/status word, a date word and a time word. Reads are combinational from the live counters. A write to the time or date word does not take effect at once. The value is held in a per-word synchroniser with two states:

- **SYNC_IDLE**: nothing is pending.
- **SYNC_HOLD**: a value is pending and the matching busy flag reads high.

The synchroniser moves between them on these transitions:

- **arm** (SYNC_IDLE to SYNC_HOLD): a write to the word.
- **re-arm** (SYNC_HOLD to SYNC_HOLD): a fresh write while pending. It replaces the held value and restarts the wait.
- **latency commit** (SYNC_HOLD to SYNC_IDLE): the fixed latency runs out.
- **tick commit** (SYNC_HOLD to SYNC_IDLE): a tick arrives first.

On either commit the held value is loaded into the counters, and the busy flag clears on the same clock edge.

Top module: `cal_rtc_core`

## Requirements
- R1: After reset the time word reads 0 (00:00:00), the date word reads day 1, month 1, year offset 0, leap flag 0 (value 0x00000101), and the control word reads 0.
- R2: The word map is: control at address 0x0, date at 0x4 and time at 0x8. All other addresses read 0.
  - Time word: seconds in [5:0], minutes in [13:8], hours in [20:16].
  - Date word: day in [4:0], month (1 to 12) in [11:8], year offset in [23:16], leap flag in [24].
  - Control word: time-busy at bit 8 and date-busy at bit 7.
- R3: A write to the time (date) word sets control bit 8 (bit 7) from the next edge. Until the commit, the word keeps reading its old running value.
- R4: With no tick, a pending value is loaded exactly SYNC_LAT (default 3) edges after the write edge, and its busy bit clears on that same edge.
- R5: A tick while a value is pending commits it on that edge. The committed word shows exactly the written value, with no one-second advance.
- R6: Each tick adds one second. Seconds roll 59 to 0 and carry into minutes, minutes roll 59 to 0 and carry into hours, and hours roll 23 to 0 and carry a day.
- R7: A day carry rolls day 30 to 1 in months 4, 6, 9 and 11, and day 31 to 1 in the other 31-day months, then increments the month.
- R8: In month 2 the day rolls from 29 to 1 when the leap flag is 1, and from 28 to 1 when it is 0.
- R9: A carry out of 12/31 gives 1/1 with the year offset plus one, wrapping 255 to 0. The leap flag is recomputed from 1970+offset by the Gregorian rule, so 2000 is a leap year and 2100 is not.
- R10: A second write to a pending word replaces the held value and restarts the SYNC_LAT wait from the new write edge.
- R11: When a date commit falls on the same edge as a day carry from the time counter, the committed date is taken and the carry is dropped.
- R12: Without a tick or a commit, both words hold still between reads. Writes to the control word or to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W (4) | Byte address of the word |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Combinational read data for `addr` |

## Verification
Two kinds of cycle coincidence are provoked. First, a write is placed so that its commit lands on the same edge as a tick: the value is written and the tick follows one cycle later. Second, a date commit is placed on the same edge as a day carry out of 23:59:59. In both cases the judgement is that the committed value appears exactly as written, with no extra second and no extra day, and that the busy bit falls on that edge. A behavioural model with integer counters follows every clock and is compared with the read word each cycle. Directed checks also cover month, February and year boundaries, including the wraps at 2000, 2100 and 2225.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int DAY_W  = 5;
    localparam int MON_W  = 4;
    localparam int YEAR_W = 8;

    localparam int TIME_W = SEC_W + MIN_W + HOUR_W;
    localparam int DATE_W = DAY_W + MON_W + YEAR_W + 1;

    typedef enum logic {
        SYNC_IDLE = 1'b0,
        SYNC_HOLD = 1'b1
    } sync_state_e;

    // Gregorian leap test on a year held as an offset from a base year.
    function automatic logic leap_of_offset(input logic [YEAR_W-1:0] off, input int base);
        int y;
        y = base + int'(off);
        return ((y % 4) == 0 && (y % 100) != 0) || ((y % 400) == 0);
    endfunction

    function automatic logic [DAY_W-1:0] month_days(input logic [MON_W-1:0] mon, input logic leap);
        logic [DAY_W-1:0] n;
        unique case (mon)
            4'd2:                     n = leap ? DAY_W'(29) : DAY_W'(28);
            4'd4, 4'd6, 4'd9, 4'd11:  n = DAY_W'(30);
            default:                  n = DAY_W'(31);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rtc_wr_sync.sv
module rtc_wr_sync
    import rtc_pkg::*;
#(
    parameter int W        = 17,
    parameter int SYNC_LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  logic         tick,
    input  logic [W-1:0] wr_data,
    output logic         busy,
    output logic         commit,
    output logic [W-1:0] held_data
);

    localparam int CNT_W = (SYNC_LAT < 2) ? 1 : $clog2(SYNC_LAT);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(SYNC_LAT - 1);

    sync_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;

    assign expire = (cnt_q == '0) || tick;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SYNC_IDLE: if (wr_stb) state_d = SYNC_HOLD;
            SYNC_HOLD: begin
                if (wr_stb)      state_d = SYNC_HOLD;   // re-arm
                else if (expire) state_d = SYNC_IDLE;   // latency or tick commit
            end
            default:   state_d = SYNC_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SYNC_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy   = 1'b0;
        commit = 1'b0;
        unique case (state_q)
            SYNC_IDLE: begin
                busy   = 1'b0;
                commit = 1'b0;
            end
            SYNC_HOLD: begin
                busy   = 1'b1;
                commit = !wr_stb && expire;
            end
            default: begin
                busy   = 1'b0;
                commit = 1'b0;
            end
        endcase
    end

    // held value and wait counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_data <= '0;
            cnt_q     <= '0;
        end else if (wr_stb) begin
            held_data <= wr_data;
            cnt_q     <= CNT_INIT;
        end else if (state_q == SYNC_HOLD && cnt_q != '0) begin
            cnt_q     <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [SEC_W-1:0]  load_sec,
    input  logic [MIN_W-1:0]  load_min,
    input  logic [HOUR_W-1:0] load_hour,
    output logic [SEC_W-1:0]  sec_q,
    output logic [MIN_W-1:0]  min_q,
    output logic [HOUR_W-1:0] hour_q,
    output logic              day_carry
);

    localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(59);
    localparam logic [MIN_W-1:0]  MIN_LAST  = MIN_W'(59);
    localparam logic [HOUR_W-1:0] HOUR_LAST = HOUR_W'(23);

    logic sec_wrap, min_wrap, hour_wrap, step;

    assign step      = tick && !load;
    assign sec_wrap  = sec_q  >= SEC_LAST;
    assign min_wrap  = min_q  >= MIN_LAST;
    assign hour_wrap = hour_q >= HOUR_LAST;
    assign day_carry = step && sec_wrap && min_wrap && hour_wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= '0;
            min_q  <= '0;
            hour_q <= '0;
        end else if (load) begin
            sec_q  <= load_sec;
            min_q  <= load_min;
            hour_q <= load_hour;
        end else if (step) begin
            if (!sec_wrap) begin
                sec_q <= sec_q + 1'b1;
            end else begin
                sec_q <= '0;
                if (!min_wrap) begin
                    min_q <= min_q + 1'b1;
                end else begin
                    min_q  <= '0;
                    hour_q <= hour_wrap ? '0 : hour_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rtc_date_cnt.sv
module rtc_date_cnt
    import rtc_pkg::*;
#(
    parameter int BASE_YEAR = 1970
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              load,
    input  logic [DAY_W-1:0]  load_day,
    input  logic [MON_W-1:0]  load_mon,
    input  logic [YEAR_W-1:0] load_year,
    input  logic              load_leap,
    output logic [DAY_W-1:0]  day_q,
    output logic [MON_W-1:0]  mon_q,
    output logic [YEAR_W-1:0] year_q,
    output logic              leap_q
);

    localparam logic [MON_W-1:0] MON_LAST = MON_W'(12);

    logic [DAY_W-1:0]  last_day;
    logic [YEAR_W-1:0] year_next;
    logic              leap_next;

    assign last_day  = month_days(mon_q, leap_q);
    assign year_next = year_q + 1'b1;
    assign leap_next = leap_of_offset(year_next, BASE_YEAR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            day_q  <= DAY_W'(1);
            mon_q  <= MON_W'(1);
            year_q <= '0;
            leap_q <= 1'b0;
        end else if (load) begin
            day_q  <= load_day;
            mon_q  <= load_mon;
            year_q <= load_year;
            leap_q <= load_leap;
        end else if (advance) begin
            if (day_q < last_day) begin
                day_q <= day_q + 1'b1;
            end else begin
                day_q <= DAY_W'(1);
                if (mon_q < MON_LAST) begin
                    mon_q <= mon_q + 1'b1;
                end else begin
                    mon_q  <= MON_W'(1);
                    year_q <= year_next;
                    leap_q <= leap_next;
                end
            end
        end
    end

endmodule

// File: rtl/cal_rtc_core.sv
module cal_rtc_core
    import rtc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int SYNC_LAT  = 3,
    parameter int BASE_YEAR = 1970
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_DATE = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFF_TIME = ADDR_W'(8);
    localparam int BIT_TBUSY = 8;
    localparam int BIT_DBUSY = 7;
    localparam int POS_MIN   = 8;
    localparam int POS_HOUR  = 16;
    localparam int POS_MON   = 8;
    localparam int POS_YEAR  = 16;
    localparam int POS_LEAP  = 24;

    logic              time_wr, date_wr;
    logic              time_busy, date_busy, time_commit, date_commit;
    logic [TIME_W-1:0] time_in, time_held;
    logic [DATE_W-1:0] date_in, date_held;
    logic              day_carry;
    logic [SEC_W-1:0]  sec_q;
    logic [MIN_W-1:0]  min_q;
    logic [HOUR_W-1:0] hour_q;
    logic [DAY_W-1:0]  day_q;
    logic [MON_W-1:0]  mon_q;
    logic [YEAR_W-1:0] year_q;
    logic              leap_q;
    logic              unused_wdata;

    assign time_wr = wr_en && (addr == OFF_TIME);
    assign date_wr = wr_en && (addr == OFF_DATE);

    assign time_in = {wdata[POS_HOUR +: HOUR_W], wdata[POS_MIN +: MIN_W], wdata[0 +: SEC_W]};
    assign date_in = {wdata[POS_LEAP], wdata[POS_YEAR +: YEAR_W],
                      wdata[POS_MON +: MON_W], wdata[0 +: DAY_W]};
    assign unused_wdata = ^{wdata[7:6], wdata[15:14], wdata[DATA_W-1:POS_LEAP+1]};

    rtc_wr_sync #(.W(TIME_W), .SYNC_LAT(SYNC_LAT)) u_time_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (time_wr),
        .tick      (tick),
        .wr_data   (time_in),
        .busy      (time_busy),
        .commit    (time_commit),
        .held_data (time_held)
    );

    rtc_wr_sync #(.W(DATE_W), .SYNC_LAT(SYNC_LAT)) u_date_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (date_wr),
        .tick      (tick),
        .wr_data   (date_in),
        .busy      (date_busy),
        .commit    (date_commit),
        .held_data (date_held)
    );

    rtc_time_cnt u_time_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (time_commit),
        .load_sec  (time_held[0 +: SEC_W]),
        .load_min  (time_held[SEC_W +: MIN_W]),
        .load_hour (time_held[SEC_W+MIN_W +: HOUR_W]),
        .sec_q     (sec_q),
        .min_q     (min_q),
        .hour_q    (hour_q),
        .day_carry (day_carry)
    );

    rtc_date_cnt #(.BASE_YEAR(BASE_YEAR)) u_date_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (day_carry),
        .load      (date_commit),
        .load_day  (date_held[0 +: DAY_W]),
        .load_mon  (date_held[DAY_W +: MON_W]),
        .load_year (date_held[DAY_W+MON_W +: YEAR_W]),
        .load_leap (date_held[DATE_W-1]),
        .day_q     (day_q),
        .mon_q     (mon_q),
        .year_q    (year_q),
        .leap_q    (leap_q)
    );

    // read packing
    always_comb begin
        rdata = '0;
        unique case (addr)
            OFF_CTRL: begin
                rdata[BIT_TBUSY] = time_busy;
                rdata[BIT_DBUSY] = date_busy;
            end
            OFF_DATE: begin
                rdata[0 +: DAY_W]         = day_q;
                rdata[POS_MON +: MON_W]   = mon_q;
                rdata[POS_YEAR +: YEAR_W] = year_q;
                rdata[POS_LEAP]           = leap_q;
            end
            OFF_TIME: begin
                rdata[0 +: SEC_W]         = sec_q;
                rdata[POS_MIN +: MIN_W]   = min_q;
                rdata[POS_HOUR +: HOUR_W] = hour_q;
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_core_checks.sv
module rtc_core_checks #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              time_busy,
    input logic              date_busy,
    input logic              day_carry,
    input logic [5:0]        sec_q,
    input logic [5:0]        min_q,
    input logic [4:0]        hour_q,
    input logic [4:0]        day_q,
    input logic [3:0]        mon_q
);

    localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(8);

    p_time_busy_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_TIME) |=> time_busy);

    p_date_busy_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DATE) |=> date_busy);

    p_tick_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (time_busy && tick && !(wr_en && addr == A_TIME)) |=> !time_busy);

    p_sec_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !time_busy && sec_q == 6'd59) |=> (sec_q == 6'd0));

    p_year_roll_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (day_carry && !date_busy && mon_q == 4'd12 && day_q == 5'd31) |=> (mon_q == 4'd1 && day_q == 5'd1));

    p_time_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !time_busy) |=> $stable({hour_q, min_q, sec_q}));

    p_date_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!day_carry && !date_busy) |=> $stable({mon_q, day_q}));

endmodule

bind cal_rtc_core rtc_core_checks #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wr_en     (wr_en),
    .addr      (addr),
    .time_busy (time_busy),
    .date_busy (date_busy),
    .day_carry (day_carry),
    .sec_q     (sec_q),
    .min_q     (min_q),
    .hour_q    (hour_q),
    .day_q     (day_q),
    .mon_q     (mon_q)
);

// File: tb/cal_rtc_core_bench.sv
`timescale 1ns/10ps
module cal_rtc_core_bench;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    cal_rtc_core #(.SYNC_LAT(LAT)) u_cal_rtc_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // ---------------- behavioural reference model ----------------
    int m_s = 0, m_m = 0, m_h = 0, m_d = 1, m_mo = 1, m_y = 0, m_lp = 0;
    int pt = 0, pt_cnt = 0, pd = 0, pd_cnt = 0;
    logic [31:0] pt_dat = '0, pd_dat = '0;

    function automatic int is_leap(int off);
        int y;
        y = 1970 + off;
        return (((y % 4) == 0 && (y % 100) != 0) || (y % 400) == 0) ? 1 : 0;
    endfunction

    function automatic int mlen(int mo, int lp);
        if (mo == 2) return lp ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] ptime(int h, int m, int s);
        return 32'((h << 16) | (m << 8) | s);
    endfunction

    function automatic logic [31:0] pdate(int d, int mo, int off, int lp);
        return 32'((lp << 24) | (off << 16) | (mo << 8) | d);
    endfunction

    function automatic logic [31:0] model_word(logic [3:0] a);
        if (a == 4'h0) return 32'((pt << 8) | (pd << 7));
        if (a == 4'h4) return pdate(m_d, m_mo, m_y, m_lp);
        if (a == 4'h8) return ptime(m_h, m_m, m_s);
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s = 0; m_m = 0; m_h = 0; m_d = 1; m_mo = 1; m_y = 0; m_lp = 0;
            pt = 0; pd = 0; pt_cnt = 0; pd_cnt = 0;
        end else begin
            int wt, wd, ct, cd, carry;
            wt = (wr_en && addr == 4'h8) ? 1 : 0;
            wd = (wr_en && addr == 4'h4) ? 1 : 0;
            ct = (pt && !wt && (pt_cnt == 0 || tick)) ? 1 : 0;
            cd = (pd && !wd && (pd_cnt == 0 || tick)) ? 1 : 0;
            carry = 0;
            if (ct) begin
                m_s = int'(pt_dat[5:0]); m_m = int'(pt_dat[13:8]); m_h = int'(pt_dat[20:16]);
            end else if (tick) begin
                m_s++;
                if (m_s >= 60) begin
                    m_s = 0; m_m++;
                    if (m_m >= 60) begin
                        m_m = 0; m_h++;
                        if (m_h >= 24) begin m_h = 0; carry = 1; end
                    end
                end
            end
            if (cd) begin
                m_d = int'(pd_dat[4:0]); m_mo = int'(pd_dat[11:8]);
                m_y = int'(pd_dat[23:16]); m_lp = int'(pd_dat[24]);
            end else if (carry) begin
                m_d++;
                if (m_d > mlen(m_mo, m_lp)) begin
                    m_d = 1; m_mo++;
                    if (m_mo > 12) begin
                        m_mo = 1; m_y = (m_y + 1) % 256; m_lp = is_leap(m_y);
                    end
                end
            end
            if (wt) begin pt = 1; pt_cnt = LAT - 1; pt_dat = wdata; end
            else if (ct) pt = 0;
            else if (pt) pt_cnt--;
            if (wd) begin pd = 1; pd_cnt = LAT - 1; pd_dat = wdata; end
            else if (cd) pd = 0;
            else if (pd) pd_cnt--;
        end
    end

    // ---------------- checking ----------------
    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: addr=%h actual=%h expected=%h at %0t", req, addr, got, exp, $time);
        end
    endtask

    // model comparison on every clock (read map and packing, R2)
    always @(negedge clk) begin
        if (rst_n && !done) check("R2 model", rdata, model_word(addr));
    end

    task automatic expect_now(string req, logic [3:0] a, logic [31:0] exp);
        addr = a;
        #0.1;
        check(req, rdata, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #0.2;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk); #0.2;
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); #0.2;
        wr_en = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk); #0.2;
        tick = 1'b1;
        @(negedge clk); #0.2;
        tick = 1'b0;
    endtask

    task automatic set_time(int h, int m, int s);
        wr(4'h8, ptime(h, m, s));
        idle(LAT);
    endtask

    task automatic set_date(int d, int mo, int off, int lp);
        wr(4'h4, pdate(d, mo, off, lp));
        idle(LAT);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        expect_now("R1 ctrl", 4'h0, 32'h0);
        expect_now("R1 time", 4'h8, 32'h0);
        expect_now("R1 date", 4'h4, 32'h0000_0101);
        expect_now("R2 unmapped", 4'hC, 32'h0);

        // R3/R4 time write latency
        wr(4'h8, ptime(10, 20, 30));
        expect_now("R3 time busy", 4'h0, 32'h100);
        expect_now("R3 old time", 4'h8, 32'h0);
        idle(LAT - 1);
        expect_now("R4 still busy", 4'h0, 32'h100);
        idle(1);
        expect_now("R4 busy clear", 4'h0, 32'h0);
        expect_now("R4 time loaded", 4'h8, ptime(10, 20, 30));

        // R3/R4 date write latency
        wr(4'h4, pdate(15, 6, 40, 0));
        expect_now("R3 date busy", 4'h0, 32'h080);
        expect_now("R3 old date", 4'h4, 32'h0000_0101);
        idle(LAT);
        expect_now("R4 date loaded", 4'h4, pdate(15, 6, 40, 0));

        // R6 second/minute/hour roll
        set_time(0, 0, 59);
        do_tick();
        expect_now("R6 sec roll", 4'h8, ptime(0, 1, 0));
        set_time(0, 59, 59);
        do_tick();
        expect_now("R6 min roll", 4'h8, ptime(1, 0, 0));
        do_tick();
        expect_now("R6 plain tick", 4'h8, ptime(1, 0, 1));

        // R9 year roll into 2000 with leap recompute
        set_time(23, 59, 59);
        set_date(31, 12, 29, 0);
        do_tick();
        expect_now("R6 hour roll", 4'h8, 32'h0);
        expect_now("R9 into 2000", 4'h4, pdate(1, 1, 30, 1));

        // R8 February
        set_time(23, 59, 59); set_date(28, 2, 30, 1); do_tick();
        expect_now("R8 leap 28->29", 4'h4, pdate(29, 2, 30, 1));
        set_time(23, 59, 59); do_tick();
        expect_now("R8 leap 29->1", 4'h4, pdate(1, 3, 30, 1));
        set_time(23, 59, 59); set_date(28, 2, 31, 0); do_tick();
        expect_now("R8 common 28->1", 4'h4, pdate(1, 3, 31, 0));

        // R7 month lengths
        set_time(23, 59, 59); set_date(30, 4, 31, 0); do_tick();
        expect_now("R7 april", 4'h4, pdate(1, 5, 31, 0));
        set_time(23, 59, 59); set_date(30, 1, 31, 0); do_tick();
        expect_now("R7 jan 30->31", 4'h4, pdate(31, 1, 31, 0));
        set_time(23, 59, 59); do_tick();
        expect_now("R7 jan 31->1", 4'h4, pdate(1, 2, 31, 0));

        // R9 2100 non-leap and 2225 wrap
        set_time(23, 59, 59); set_date(31, 12, 129, 0); do_tick();
        expect_now("R9 into 2100", 4'h4, pdate(1, 1, 130, 0));
        set_time(23, 59, 59); set_date(31, 12, 255, 0); do_tick();
        expect_now("R9 wrap 2225", 4'h4, pdate(1, 1, 0, 0));

        // R5 tick commits pending value without advance
        wr(4'h8, ptime(5, 6, 7));
        tick = 1'b1;
        @(negedge clk); #0.2;
        tick = 1'b0;
        expect_now("R5 value", 4'h8, ptime(5, 6, 7));
        expect_now("R5 busy clear", 4'h0, 32'h0);

        // R10 rewrite restarts wait
        wr(4'h8, ptime(1, 1, 1));
        wr(4'h8, ptime(2, 2, 2));
        idle(LAT - 1);
        expect_now("R10 still busy", 4'h0, 32'h100);
        expect_now("R10 old value", 4'h8, ptime(5, 6, 7));
        idle(1);
        expect_now("R10 new value", 4'h8, ptime(2, 2, 2));

        // R11 date commit on day carry edge
        set_time(23, 59, 59);
        set_date(10, 3, 50, 0);
        wr(4'h4, pdate(15, 6, 40, 0));
        tick = 1'b1;
        @(negedge clk); #0.2;
        tick = 1'b0;
        expect_now("R11 date wins", 4'h4, pdate(15, 6, 40, 0));
        expect_now("R11 time rolled", 4'h8, 32'h0);

        // R12 ignored writes and stability
        wr(4'h0, 32'hFFFF_FFFF);
        wr(4'hC, 32'hFFFF_FFFF);
        expect_now("R12 ctrl ignored", 4'h0, 32'h0);
        idle(10);
        expect_now("R12 time stable", 4'h8, 32'h0);
        expect_now("R12 date stable", 4'h4, pdate(15, 6, 40, 0));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule